// File: doc/BRIEF.md
# Host Register File with Serial-Interrupt Handshake

This block is the microcontroller-facing side of a byte-oriented I2C controller. A host reaches four byte-wide locations through a two-bit address, a select line and separate read and write strobes. The locations hold the control byte, the own slave address, the transfer data byte and the timeout setting, and they return the status code. The bit-level serial engine sits on the other side and talks to the block through a small handshake. It raises a request that carries a state code and the byte it last moved. It reports a bus STOP. It receives a one-cycle resume pulse whenever the host writes the control byte.

While the serial-interrupt flag is set, the engine is stalled and the data byte and status code stay frozen. The host reads the status, reloads data if it needs to, and then writes the control byte. That write drops the flag, releases the active-low interrupt line and lets the engine go on. Reset is synchronous and active-high.

Top module: `i2c_host_regs`

## Requirements
- R1: Bytes written to location 1 (data), 2 (own address) and 3 (control) read back unchanged. The one exception is control bit 3, which the host cannot set.
- R2: After reset, location 0 reads F8h, locations 1, 2 and 3 read 00h, the timeout output is FFh, irq_n is 1 and eng_resume is 0.
- R3: Location 0 is shared. A write there loads the timeout byte, which appears on `tout`, and leaves the status unchanged. A read there returns the status.
- R4: Control bit 7 drives `ctl_aa`, bit 6 drives `ctl_en`, bit 5 drives `ctl_sta`, bit 4 drives `ctl_sto`, bit 3 is the interrupt flag, and bits 2..0 drive `ctl_rate`.
- R5: A host write to control clears the interrupt flag. The flag is clear and irq_n is 1 on the edge that takes the write, and `eng_resume` is 1 for exactly that one cycle. A 1 written to bit 3 is ignored.
- R6: When the flag is clear, an engine request with a code other than 11111b sets the flag, loads the code into status bits 7..3 and loads `eng_rx` into the data byte, all on the same edge.
- R7: An engine request with code 11111b (status F8h) updates the status but does not set the flag and does not change the data byte.
- R8: `eng_stop_seen` clears control bit 4 on the next edge.
- R9: Status bits 2..0 always read 0.
- R10: irq_n is registered. It is 0 exactly when the flag and control bit 6 are both 1, and it changes on the same edge as the flag.
- R11: While the flag is set, engine requests are ignored: status and data hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Block select for host accesses |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Register location |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when not reading |
| irq_n | output | 1 | Interrupt, active low, registered |
| eng_set_si | input | 1 | Engine request: new state entered |
| eng_code | input | 5 | State code for status bits 7..3 |
| eng_rx | input | 8 | Byte last transferred on the bus |
| eng_stop_seen | input | 1 | STOP observed on the bus |
| eng_resume | output | 1 | One-cycle pulse on host control write |
| ctl_aa | output | 1 | Acknowledge enable |
| ctl_en | output | 1 | Serial interface enable |
| ctl_sta | output | 1 | START request |
| ctl_sto | output | 1 | STOP request |
| ctl_rate | output | 3 | Clock rate select |
| own_addr | output | 8 | Own slave address byte |
| tx_byte | output | 8 | Data byte for the engine |
| tout | output | 8 | Timeout setting |

## Verification
The bench builds the block with its default parameters: an idle code of 11111b and a timeout reset of FFh. These defaults make the F8h reset read-back and the non-interrupting idle request directly observable. They also let the bench tell the shared location 0 apart from the four data-holding registers. With them the bench can reach the collisions that matter: a request arriving while the flag is already set, a control write that tries to set the flag, and a request that arrives while interrupts are disabled.

// File: rtl/i2c_host_regs.sv
module i2c_host_regs #(
  parameter logic [4:0] IDLE_CODE = 5'h1F,
  parameter logic [7:0] TOUT_INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq_n,
  input  logic       eng_set_si,
  input  logic [4:0] eng_code,
  input  logic [7:0] eng_rx,
  input  logic       eng_stop_seen,
  output logic       eng_resume,
  output logic       ctl_aa,
  output logic       ctl_en,
  output logic       ctl_sta,
  output logic       ctl_sto,
  output logic [2:0] ctl_rate,
  output logic [7:0] own_addr,
  output logic [7:0] tx_byte,
  output logic [7:0] tout
);
  localparam logic [1:0] LOC_STAT = 2'd0;
  localparam logic [1:0] LOC_DATA = 2'd1;
  localparam logic [1:0] LOC_OWN  = 2'd2;
  localparam logic [1:0] LOC_CTL  = 2'd3;
  localparam int SI_BIT = 3;

  logic [7:0] ctl_q, data_q, own_q, tout_q;
  logic [4:0] code_q;

  wire host_wr  = sel & wr_en;
  wire wr_ctl   = host_wr && (addr == LOC_CTL);
  wire wr_data  = host_wr && (addr == LOC_DATA);
  wire wr_own   = host_wr && (addr == LOC_OWN);
  wire wr_tout  = host_wr && (addr == LOC_STAT);
  wire si_q     = ctl_q[SI_BIT];
  wire eng_take = eng_set_si & ~si_q;
  wire eng_arm  = eng_take && (eng_code != IDLE_CODE);
  wire si_d     = eng_arm | (si_q & ~wr_ctl);
  wire en_d     = wr_ctl ? wdata[6] : ctl_q[6];
  wire sto_d    = eng_stop_seen ? 1'b0 : (wr_ctl ? wdata[4] : ctl_q[4]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= 8'h00;
      data_q     <= 8'h00;
      own_q      <= 8'h00;
      tout_q     <= TOUT_INIT;
      code_q     <= IDLE_CODE;
      irq_n      <= 1'b1;
      eng_resume <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_q[7:5] <= wdata[7:5];
        ctl_q[2:0] <= wdata[2:0];
      end
      ctl_q[4]      <= sto_d;
      ctl_q[SI_BIT] <= si_d;
      irq_n         <= ~(si_d & en_d);
      eng_resume    <= wr_ctl;
      if (eng_arm)      data_q <= eng_rx;
      else if (wr_data) data_q <= wdata;
      if (wr_own)   own_q  <= wdata;
      if (wr_tout)  tout_q <= wdata;
      if (eng_take) code_q <= eng_code;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (sel && rd_en) begin
      case (addr)
        LOC_STAT: rdata = {code_q, 3'b000};
        LOC_DATA: rdata = data_q;
        LOC_OWN:  rdata = own_q;
        default:  rdata = ctl_q;
      endcase
    end
  end

  assign ctl_aa   = ctl_q[7];
  assign ctl_en   = ctl_q[6];
  assign ctl_sta  = ctl_q[5];
  assign ctl_sto  = ctl_q[4];
  assign ctl_rate = ctl_q[2:0];
  assign own_addr = own_q;
  assign tx_byte  = data_q;
  assign tout     = tout_q;

  // R5
  ctl_write_release_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !eng_set_si) |=> (irq_n && !ctl_q[SI_BIT] && eng_resume));
  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> (ctl_q[SI_BIT] && ctl_en));
  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    eng_stop_seen |=> !ctl_sto);
  // R11
  frozen_while_si_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[SI_BIT] && eng_set_si && !wr_data) |=> ($stable(code_q) && $stable(data_q)));
  // R7
  idle_no_si_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[SI_BIT] && eng_set_si && eng_code == IDLE_CODE) |=> !ctl_q[SI_BIT]);
  // R9
  status_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && rd_en && addr == LOC_STAT) |-> (rdata[2:0] == 3'b000));
endmodule

// File: tb/test_i2c_host_regs.sv
module test_i2c_host_regs;
  logic clk = 0, rst = 1, sel = 0, rd_en = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, eng_rx = 0, own_addr, tx_byte, tout;
  logic irq_n, eng_set_si = 0, eng_stop_seen = 0, eng_resume;
  logic [4:0] eng_code = 0;
  logic ctl_aa, ctl_en, ctl_sta, ctl_sto;
  logic [2:0] ctl_rate;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  i2c_host_regs i_i2c_host_regs (
    .clk(clk), .rst(rst), .sel(sel), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .eng_set_si(eng_set_si),
    .eng_code(eng_code), .eng_rx(eng_rx), .eng_stop_seen(eng_stop_seen),
    .eng_resume(eng_resume), .ctl_aa(ctl_aa), .ctl_en(ctl_en), .ctl_sta(ctl_sta),
    .ctl_sto(ctl_sto), .ctl_rate(ctl_rate), .own_addr(own_addr), .tx_byte(tx_byte),
    .tout(tout));

  // {addr, write byte, expected read-back}
  localparam logic [17:0] VECS [6] = '{
    {2'd1, 8'hA5, 8'hA5}, {2'd2, 8'h5B, 8'h5B}, {2'd3, 8'hEF, 8'hE7},
    {2'd1, 8'h3C, 8'h3C}, {2'd2, 8'hFE, 8'hFE}, {2'd3, 8'h00, 8'h00}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr_en = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd_en = 1; addr = a;
    #1 d = rdata;
    sel = 0; rd_en = 0;
  endtask

  task automatic eng(input logic [4:0] c, input logic [7:0] b);
    @(negedge clk); eng_set_si = 1; eng_code = c; eng_rx = b;
    @(negedge clk); eng_set_si = 0;
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R2 reset state
    rd(2'd0, rv); chk("R2 status", rv, 8'hF8);
    rd(2'd1, rv); chk("R2 data", rv, 8'h00);
    rd(2'd2, rv); chk("R2 own", rv, 8'h00);
    rd(2'd3, rv); chk("R2 ctl", rv, 8'h00);
    chk("R2 tout", tout, 8'hFF);
    chk("R2 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R2 resume", {7'd0, eng_resume}, 8'h00);
    // R1 table walk
    foreach (VECS[i]) begin
      wr(VECS[i][17:16], VECS[i][15:8]);
      rd(VECS[i][17:16], rv);
      chk("R1 readback", rv, VECS[i][7:0]);
    end
    // R3 shared location
    wr(2'd0, 8'h2D);
    chk("R3 tout", tout, 8'h2D);
    rd(2'd0, rv); chk("R3 status kept", rv, 8'hF8);
    // R4 field positions
    wr(2'd3, 8'hC5);
    chk("R4 fields", {ctl_aa, ctl_en, ctl_sta, ctl_sto, 1'b0, ctl_rate}, 8'hC5);
    wr(2'd3, 8'h30);
    chk("R4 sta/sto", {ctl_aa, ctl_en, ctl_sta, ctl_sto, 4'd0}, 8'h30);
    // R6 / R10 engine request
    wr(2'd3, 8'h40);
    eng(5'h08, 8'h9A);
    chk("R10 irq low", {7'd0, irq_n}, 8'h00);
    rd(2'd0, rv); chk("R6 status", rv, 8'h40);
    chk("R9 low bits", {5'd0, rv[2:0]}, 8'h00);
    rd(2'd1, rv); chk("R6 data", rv, 8'h9A);
    rd(2'd3, rv); chk("R6 ctl SI", rv, 8'h48);
    // R11 ignored while set
    eng(5'h0A, 8'h11);
    rd(2'd0, rv); chk("R11 status held", rv, 8'h40);
    rd(2'd1, rv); chk("R11 data held", rv, 8'h9A);
    // R5 release with attempt to set bit 3
    @(negedge clk); sel = 1; wr_en = 1; addr = 2'd3; wdata = 8'h48;
    @(posedge clk); #1;
    chk("R5 resume", {7'd0, eng_resume}, 8'h01);
    chk("R5 irq_n", {7'd0, irq_n}, 8'h01);
    @(negedge clk); sel = 0; wr_en = 0;
    @(posedge clk); #1;
    chk("R5 resume one cycle", {7'd0, eng_resume}, 8'h00);
    rd(2'd3, rv); chk("R5 SI cleared", rv, 8'h40);
    // R7 idle code
    eng(5'h1F, 8'h77);
    chk("R7 irq_n", {7'd0, irq_n}, 8'h01);
    rd(2'd3, rv); chk("R7 no SI", rv, 8'h40);
    rd(2'd1, rv); chk("R7 data kept", rv, 8'h9A);
    rd(2'd0, rv); chk("R7 status", rv, 8'hF8);
    // R10 gating by enable
    wr(2'd3, 8'h00);
    eng(5'h10, 8'h33);
    chk("R10 disabled irq", {7'd0, irq_n}, 8'h01);
    rd(2'd3, rv); chk("R10 SI set", rv, 8'h08);
    rd(2'd1, rv); chk("R6 data disabled", rv, 8'h33);
    wr(2'd3, 8'h40);
    chk("R10 irq after", {7'd0, irq_n}, 8'h01);
    // R8 stop clears STO
    wr(2'd3, 8'h50);
    rd(2'd3, rv); chk("R8 sto set", rv, 8'h50);
    @(negedge clk); eng_stop_seen = 1;
    @(negedge clk); eng_stop_seen = 0;
    rd(2'd3, rv); chk("R8 sto cleared", rv, 8'h40);
    chk("R8 port", {7'd0, ctl_sto}, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule